// File: doc/BRIEF.md
# Transmit-Only Serial Slave With Attention Request

This block sends fixed-length report packets to a host over a four-wire style serial link in which the host is master and this block is a one-way slave. A producer beside it presents one packet at a time: either 2 bytes (short) or 4 bytes (long), held stable with a valid flag until the block signals that the packet has gone. While a packet waits, the block pulls an active-low attention line. The host answers by pulling its active-low select, then clocks the packet out one byte per eight clock pulses.

The host clock idles high. The block presents a new bit after each falling edge and the host captures it on the rising edge. A static configuration input picks whether each byte leaves most-significant bit first or least-significant bit first. The data pin is driven only during a transfer and is released (enable low) otherwise. Host clock and select come from another clock domain: they are brought in through a synchronizer and their edges are found in the system clock domain, so each host clock phase must last several system cycles.

If the host does not select the block within a set number of cycles after attention drops, the block withdraws the request for a back-off period and then asks again. If select rises partway through a packet, the transfer is abandoned and the whole packet is offered again from its first bit. Select may also stay low between packets. The next packet then starts as soon as attention falls again.

Top module: `spiTxAttn`

## Requirements
- R1: After reset, attnN is 1, sdoOe is 0, sdo is 0 and pktTaken is 0.
- R2: When pktValid is high in the idle state, attnN goes low on the next clock and stays low until the packet ends, is aborted or times out.
- R3: sdoOe is 1 only while a transfer is in progress after the synchronized select was seen low; before select, sdoOe and sdo are 0 even with attnN low.
- R4: Each synchronized falling edge of sclkIn during a transfer places the next bit on sdo; bytes leave in rising order, byte k being pktData[8k+7:8k], so byte 0 is pktData[7:0].
- R5: With msbFirst = 1 each byte is sent from bit 7 down to bit 0; with msbFirst = 0 from bit 0 up to bit 7.
- R6: With pktLong = 1 a packet is 4 bytes, with pktLong = 0 it is 2 bytes; the packet ends on the synchronized rising edge that completes the eighth bit of the last byte. pktTaken is high for exactly that one cycle, and on the next cycle attnN is 1 and sdoOe is 0.
- R7: With select held low across packets, the next packet's transfer begins one cycle after attnN falls, with no select toggle.
- R8: If select is not seen low within TIMEOUT_CYC cycles of attnN going low, attnN is high for exactly RETRY_CYC cycles and then falls again for the same packet.
- R9: If select rises during a transfer, the transfer stops without pktTaken, attnN is high for one cycle, and the next transfer of that packet restarts at byte 0, first bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| msbFirst | input | 1 | Bit order: 1 sends bit 7 first, 0 sends bit 0 first |
| pktValid | input | 1 | A packet is presented and held stable |
| pktLong | input | 1 | 1 = 4-byte packet, 0 = 2-byte packet |
| pktData | input | LONG_BYTES*8 | Packet bytes, byte 0 in the low bits |
| pktTaken | output | 1 | One-cycle pulse when the packet has been fully sent |
| attnN | output | 1 | Active-low request to the host |
| sclkIn | input | 1 | Host serial clock, idle high, asynchronous |
| ssNIn | input | 1 | Host active-low select, asynchronous |
| sdo | output | 1 | Serial data toward the host, 0 when not enabled |
| sdoOe | output | 1 | Output enable for the data pin's tristate buffer |

## Verification
The bench builds the block with TIMEOUT_CYC = 60 and RETRY_CYC = 25 and keeps the default 4-byte and 2-byte packet lengths and two synchronizer stages. The short wait limits bring the withdraw-and-retry path within a few hundred cycles, so the exact length of the low and high attention phases can be measured and compared against the limits. Both packet lengths, both bit orders, a mid-packet abort and back-to-back packets with select held low are run under a cycle-by-cycle model, and the bytes the host captures on rising edges are compared with the presented data.

// File: rtl/spiTxPkg.sv
package spiTxPkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_REQ     = 2'd1,
    ST_XFER    = 2'd2,
    ST_BACKOFF = 2'd3
  } txState_e;

  // Strobes from control to datapath; clear has priority over the others.
  typedef struct packed {
    logic clear;
    logic drive;
    logic advance;
  } txStrobe_t;

endpackage

// File: rtl/spiTxSync.sv
module spiTxSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclkPin,
  input  logic ssNPin,
  output logic sclkFall,
  output logic sclkRise,
  output logic ssActive
);

  logic [STAGES-1:0] sclkSync;
  logic [STAGES-1:0] ssSync;
  logic              sclkPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= '1;
      ssSync   <= '1;
      sclkPrev <= 1'b1;
    end else begin
      sclkSync <= {sclkSync[STAGES-2:0], sclkPin};
      ssSync   <= {ssSync[STAGES-2:0], ssNPin};
      sclkPrev <= sclkSync[STAGES-1];
    end
  end

  assign sclkFall = sclkPrev & ~sclkSync[STAGES-1];
  assign sclkRise = ~sclkPrev & sclkSync[STAGES-1];
  assign ssActive = ~ssSync[STAGES-1];

endmodule

// File: rtl/spiTxCtrl.sv
module spiTxCtrl
  import spiTxPkg::*;
#(
  parameter int TIMEOUT_CYC = 40000,
  parameter int RETRY_CYC   = 4000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      pktValid,
  input  logic      sclkFall,
  input  logic      sclkRise,
  input  logic      ssActive,
  input  logic      atLastBit,
  output txStrobe_t strobe,
  output logic      attnN,
  output logic      sdoOe,
  output logic      pktTaken
);

  localparam int WAIT_MAX = (TIMEOUT_CYC > RETRY_CYC) ? TIMEOUT_CYC : RETRY_CYC;
  localparam int CNT_W    = $clog2(WAIT_MAX + 1);

  txState_e          state, stateNxt;
  logic [CNT_W-1:0]  waitCnt, waitNxt;
  logic              inXfer, abort, done;

  assign inXfer = (state == ST_XFER);
  assign abort  = inXfer & ~ssActive;
  assign done   = inXfer & ssActive & sclkRise & atLastBit;

  always_comb begin
    stateNxt = state;
    waitNxt  = waitCnt;
    unique case (state)
      ST_IDLE: begin
        if (pktValid) begin
          stateNxt = ST_REQ;
          waitNxt  = '0;
        end
      end
      ST_REQ: begin
        if (ssActive) begin
          stateNxt = ST_XFER;
        end else if (waitCnt == CNT_W'(TIMEOUT_CYC - 1)) begin
          stateNxt = ST_BACKOFF;
          waitNxt  = '0;
        end else begin
          waitNxt = waitCnt + CNT_W'(1);
        end
      end
      ST_XFER: begin
        if (abort || done) stateNxt = ST_IDLE;
      end
      ST_BACKOFF: begin
        if (waitCnt == CNT_W'(RETRY_CYC - 1)) begin
          stateNxt = pktValid ? ST_REQ : ST_IDLE;
          waitNxt  = '0;
        end else begin
          waitNxt = waitCnt + CNT_W'(1);
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
    end else begin
      state   <= stateNxt;
      waitCnt <= waitNxt;
    end
  end

  assign strobe.clear   = ((state == ST_REQ) & ssActive) | abort | done;
  assign strobe.drive   = inXfer & ssActive & sclkFall;
  assign strobe.advance = inXfer & ssActive & sclkRise;

  assign attnN    = ~((state == ST_REQ) | inXfer);
  assign sdoOe    = inXfer;
  assign pktTaken = done;

  // R2: a waiting packet pulls attention on the next clock
  a_r2_req_on_valid: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && pktValid) |=> !attnN);

  // R6: attention released and pin undriven after the last byte
  a_r6_release_after_done: assert property (@(posedge clk) disable iff (!rstN)
    pktTaken |=> (attnN && !sdoOe));

  // R3: driving only starts after select was seen low
  a_r3_oe_after_select: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdoOe) |-> $past(ssActive));

  // R9: select lost mid-transfer drops the request for a cycle with no completion
  a_r9_abort_release: assert property (@(posedge clk) disable iff (!rstN)
    (sdoOe && !ssActive) |=> (attnN && !pktTaken));

  // R8: the request wait never passes its limit
  a_r8_wait_bound: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REQ) |-> (waitCnt < CNT_W'(TIMEOUT_CYC)));

endmodule

// File: rtl/spiTxData.sv
module spiTxData
  import spiTxPkg::*;
#(
  parameter int LONG_BYTES  = 4,
  parameter int SHORT_BYTES = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  txStrobe_t               strobe,
  input  logic                    msbFirst,
  input  logic                    pktLong,
  input  logic [LONG_BYTES*8-1:0] pktData,
  output logic                    sdoBit,
  output logic                    atLastBit
);

  localparam int BYTE_W = (LONG_BYTES > 1) ? $clog2(LONG_BYTES) : 1;

  logic [2:0]        bitIdx;
  logic [BYTE_W-1:0] byteIdx;
  logic [BYTE_W-1:0] lastIdx;
  logic [7:0]        curByte;
  logic              nextBit;

  assign lastIdx   = pktLong ? BYTE_W'(LONG_BYTES - 1) : BYTE_W'(SHORT_BYTES - 1);
  assign curByte   = pktData[{byteIdx, 3'b000} +: 8];
  assign nextBit   = msbFirst ? curByte[3'd7 - bitIdx] : curByte[bitIdx];
  assign atLastBit = (bitIdx == 3'd7) && (byteIdx == lastIdx);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitIdx  <= '0;
      byteIdx <= '0;
      sdoBit  <= 1'b0;
    end else if (strobe.clear) begin
      bitIdx  <= '0;
      byteIdx <= '0;
      sdoBit  <= 1'b0;
    end else begin
      if (strobe.drive) sdoBit <= nextBit;
      if (strobe.advance) begin
        bitIdx <= bitIdx + 3'd1;
        if (bitIdx == 3'd7) byteIdx <= byteIdx + BYTE_W'(1);
      end
    end
  end

  // R6: control never advances past the last bit without clearing
  a_r6_no_overrun: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !strobe.clear) |-> !atLastBit);

  // R4: eighth captured bit wraps to the next byte
  a_r4_bit_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !strobe.clear && bitIdx == 3'd7) |=> (bitIdx == 3'd0));

  // R9: a clear restarts the packet at its first bit
  a_r9_restart_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (bitIdx == 3'd0 && byteIdx == '0));

endmodule

// File: rtl/spiTxAttn.sv
module spiTxAttn
  import spiTxPkg::*;
#(
  parameter int LONG_BYTES  = 4,
  parameter int SHORT_BYTES = 2,
  parameter int SYNC_STAGES = 2,
  parameter int TIMEOUT_CYC = 40000,
  parameter int RETRY_CYC   = 4000
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    msbFirst,
  input  logic                    pktValid,
  input  logic                    pktLong,
  input  logic [LONG_BYTES*8-1:0] pktData,
  output logic                    pktTaken,
  output logic                    attnN,
  input  logic                    sclkIn,
  input  logic                    ssNIn,
  output logic                    sdo,
  output logic                    sdoOe
);

  logic      sclkFall, sclkRise, ssActive, atLastBit, sdoBit;
  txStrobe_t strobe;

  spiTxSync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .sclkPin(sclkIn), .ssNPin(ssNIn),
    .sclkFall(sclkFall), .sclkRise(sclkRise), .ssActive(ssActive)
  );

  spiTxCtrl #(.TIMEOUT_CYC(TIMEOUT_CYC), .RETRY_CYC(RETRY_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .pktValid(pktValid),
    .sclkFall(sclkFall), .sclkRise(sclkRise), .ssActive(ssActive),
    .atLastBit(atLastBit), .strobe(strobe),
    .attnN(attnN), .sdoOe(sdoOe), .pktTaken(pktTaken)
  );

  spiTxData #(.LONG_BYTES(LONG_BYTES), .SHORT_BYTES(SHORT_BYTES)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .msbFirst(msbFirst),
    .pktLong(pktLong), .pktData(pktData),
    .sdoBit(sdoBit), .atLastBit(atLastBit)
  );

  assign sdo = sdoOe & sdoBit;

endmodule

// File: tb/tb_spiTxAttn.sv
module tb_spiTxAttn;

  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 60;
  localparam int RTY        = 25;
  localparam int HALF       = 6;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        msbFirst = 1'b1;
  logic        pktValid;
  logic        pktLong = 1'b1;
  logic [31:0] pktData = '0;
  logic        pktTaken, attnN, sdo, sdoOe;
  logic        sclkIn = 1'b1;
  logic        ssNIn = 1'b1;

  spiTxAttn #(.TIMEOUT_CYC(TMO), .RETRY_CYC(RTY)) dut (
    .clk(clk), .rstN(rstN), .msbFirst(msbFirst), .pktValid(pktValid),
    .pktLong(pktLong), .pktData(pktData), .pktTaken(pktTaken),
    .attnN(attnN), .sclkIn(sclkIn), .ssNIn(ssNIn), .sdo(sdo), .sdoOe(sdoOe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int stimCmp = 0, stimBad = 0, modelCmp = 0, modelBad = 0;
  int offered = 0, loaded = 0, takenCnt = 0, cycles = 0;
  bit finished = 1'b0;

  // Producer: presents one offered packet at a time, drops it when taken.
  always @(posedge clk) begin
    if (!rstN) begin
      pktValid <= 1'b0;
      loaded   <= 0;
    end else if (pktTaken) begin
      pktValid <= 1'b0;
    end else if (!pktValid && offered > loaded) begin
      pktValid <= 1'b1;
      loaded   <= loaded + 1;
    end
  end

  // Behavioural reference model, one step per clock.
  bit mS1, mS2, mPrev, mA1, mA2, mSdo;
  int mSt, mWait, mBit, mByte;

  function automatic bit modelDone();
    int lastB = pktLong ? 3 : 1;
    return (mSt == 2) && !mA2 && (!mPrev && mS2) && (mBit == 7) && (mByte == lastB);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mS1 = 1; mS2 = 1; mPrev = 1; mA1 = 1; mA2 = 1;
      mSt = 0; mWait = 0; mBit = 0; mByte = 0; mSdo = 0;
    end else begin
      bit fall, rise, act, done, abrt, clr;
      logic [7:0] b;
      fall = mPrev && !mS2;
      rise = !mPrev && mS2;
      act  = !mA2;
      done = modelDone();
      abrt = (mSt == 2) && !act;
      clr  = ((mSt == 1) && act) || abrt || done;
      if (clr) begin
        mBit = 0; mByte = 0; mSdo = 0;
      end else if (mSt == 2 && act) begin
        b = 8'(pktData >> (8 * mByte));
        if (fall) mSdo = msbFirst ? b[7 - mBit] : b[mBit];
        if (rise) begin
          if (mBit == 7) begin mBit = 0; mByte++; end
          else mBit++;
        end
      end
      case (mSt)
        0: if (pktValid) begin mSt = 1; mWait = 0; end
        1: if (act) mSt = 2;
           else if (mWait == TMO - 1) begin mSt = 3; mWait = 0; end
           else mWait++;
        2: if (abrt || done) mSt = 0;
        default: if (mWait == RTY - 1) begin mSt = pktValid ? 1 : 0; mWait = 0; end
                 else mWait++;
      endcase
      mPrev = mS2; mS2 = mS1; mS1 = sclkIn;
      mA2 = mA1; mA1 = ssNIn;
    end
  end

  task automatic checkM(input string tag, input logic act, input logic exp);
    modelCmp++;
    if (act !== exp) begin
      modelBad++;
      $display("FAIL %s actual=%0b expected=%0b at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      checkM("R2 attnN vs model", attnN, !(mSt == 1 || mSt == 2));
      checkM("R3 sdoOe vs model", sdoOe, mSt == 2);
      checkM("R4 sdo vs model", sdo, (mSt == 2) && mSdo);
      checkM("R6 pktTaken vs model", pktTaken, modelDone());
      if (pktTaken) takenCnt++;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    stimCmp++;
    if (act !== exp) begin
      stimBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); #1; endtask
  task automatic ticks(input int n); for (int i = 0; i < n; i++) tick(); endtask

  task automatic hostBit(output logic v);
    sclkIn = 1'b0; ticks(HALF);
    v = sdo;
    sclkIn = 1'b1; ticks(HALF);
  endtask

  task automatic hostByte(output logic [7:0] b);
    logic v;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      hostBit(v);
      if (msbFirst) b[7 - i] = v; else b[i] = v;
    end
  endtask

  task automatic runPacket(input string tag, input int nBytes, input logic [31:0] data);
    logic [7:0] got;
    for (int k = 0; k < nBytes; k++) begin
      hostByte(got);
      check(tag, {24'd0, got}, {24'd0, data[8*k +: 8]});
      ticks(4);
    end
  endtask

  task automatic offer(input logic [31:0] data, input logic isLong);
    pktData = data; pktLong = isLong; offered++;
  endtask

  task automatic waitAttn();
    for (int i = 0; i < 500 && attnN; i++) tick();
  endtask

  task automatic summary(input int extraBad);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***",
             stimCmp + modelCmp, stimBad + modelBad + extraBad);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      finished = 1'b1;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      summary(1);
      $finish;
    end
  end

  initial begin
    int lowRun, highRun, tk;
    logic v;
    logic [7:0] junk;
    ticks(3);
    // R1: reset state
    check("R1 attnN in reset", {31'd0, attnN}, 32'd1);
    check("R1 sdoOe in reset", {31'd0, sdoOe}, 32'd0);
    check("R1 sdo in reset", {31'd0, sdo}, 32'd0);
    check("R1 pktTaken in reset", {31'd0, pktTaken}, 32'd0);
    rstN = 1'b1;
    ticks(3);
    check("R1 attnN idle after reset", {31'd0, attnN}, 32'd1);

    // R2/R3/R4/R6: long packet, MSB first, select toggled
    msbFirst = 1'b1;
    offer(32'hA5C3_0F81, 1'b1);
    waitAttn();
    check("R2 attention low for pending packet", {31'd0, attnN}, 32'd0);
    ticks(5);
    check("R3 no drive before select", {31'd0, sdoOe}, 32'd0);
    check("R3 attention still low before select", {31'd0, attnN}, 32'd0);
    ssNIn = 1'b0; ticks(4);
    check("R3 drive after select", {31'd0, sdoOe}, 32'd1);
    runPacket("R4 long packet byte", 4, 32'hA5C3_0F81);
    ticks(4);
    check("R6 attention released after 4 bytes", {31'd0, attnN}, 32'd1);
    check("R6 output released after 4 bytes", {31'd0, sdoOe}, 32'd0);
    check("R6 one completion pulse", takenCnt, 32'd1);
    ssNIn = 1'b1; ticks(6);

    // R5/R6: short packet, LSB first
    msbFirst = 1'b0;
    offer(32'h0000_3C96, 1'b0);
    waitAttn();
    ssNIn = 1'b0; ticks(4);
    runPacket("R5 lsb-first short byte", 2, 32'h0000_3C96);
    ticks(4);
    check("R6 attention released after 2 bytes", {31'd0, attnN}, 32'd1);
    check("R6 second completion", takenCnt, 32'd2);

    // R7: select held low across two packets
    msbFirst = 1'b1;
    offer(32'h5A5A_F00D, 1'b1);
    waitAttn(); ticks(2);
    runPacket("R7 first back-to-back byte", 4, 32'h5A5A_F00D);
    ticks(6);
    offer(32'h0000_E71B, 1'b0);
    waitAttn(); ticks(2);
    check("R7 transfer starts without select toggle", {31'd0, sdoOe}, 32'd1);
    runPacket("R7 second back-to-back byte", 2, 32'h0000_E71B);
    ticks(4);
    check("R7 completions", takenCnt, 32'd4);
    ssNIn = 1'b1; ticks(6);

    // R9: abort mid-packet, then full resend from byte 0
    offer(32'h1234_5678, 1'b1);
    waitAttn();
    ssNIn = 1'b0; ticks(4);
    hostByte(junk);
    hostBit(v); hostBit(v);
    tk = takenCnt;
    ssNIn = 1'b1; ticks(5);
    check("R9 no completion on abort", takenCnt, tk);
    check("R9 request raised again", {31'd0, attnN}, 32'd0);
    check("R9 output released on abort", {31'd0, sdoOe}, 32'd0);
    ssNIn = 1'b0; ticks(4);
    runPacket("R9 resent byte", 4, 32'h1234_5678);
    ticks(4);
    check("R9 completion after resend", takenCnt, tk + 1);
    ssNIn = 1'b1; ticks(6);

    // R8: timeout and back-off
    offer(32'h0000_C0DE, 1'b0);
    waitAttn();
    lowRun = 0;
    while (!attnN && lowRun < 1000) begin lowRun++; tick(); end
    highRun = 0;
    while (attnN && highRun < 1000) begin highRun++; tick(); end
    check("R8 request window length", lowRun, TMO);
    check("R8 back-off length", highRun, RTY);
    ssNIn = 1'b0; ticks(4);
    runPacket("R8 byte after retry", 2, 32'h0000_C0DE);
    ticks(4);
    check("R8 completion after retry", takenCnt, tk + 2);
    ssNIn = 1'b1; ticks(6);

    finished = 1'b1;
    summary(0);
    $finish;
  end

endmodule